// File: doc/BRIEF.md
# Endpoint Mismatch Interrupt Counter

This block decides when a USB device controller should tell software that IN tokens keep arriving for an endpoint other than the one it expects. Each token produces a one-cycle strobe, together with a flag that says whether the token hit the expected IN endpoint. Every miss counts an internal down-counter down by one. Only an unbroken run of misses as long as the programmed count raises the interrupt, because any hit restarts the run.

Software sets the run length through a small register port. A 5-bit reload value sits at address 0. A status word sits at address 1, and its bit 0 is a sticky interrupt flag that software clears by writing a one to it. The block drives a one-cycle interrupt pulse and a level copy of the sticky flag for use by an interrupt controller.

Top module: `emi_ctr`

## Requirements
- R1: After a synchronous reset the reload value is 8, the internal counter holds 8, and irq_pulse, irq_sticky and csr_rdata are all 0.
- R2: A token strobe with tok_match low decrements the counter. The miss strobe that arrives while the counter holds 1 is the expiry, and irq_pulse is high for exactly the one cycle after that strobe. With a reload value N of 1 or more, the Nth consecutive miss raises the pulse.
- R3: A cycle with tok_vld low leaves the counter unchanged, so misses separated by idle cycles still count as consecutive.
- R4: A token strobe with tok_match high reloads the counter from the reload value and raises no pulse.
- R5: On expiry the counter reloads from the reload value, so the next pulse needs another full run of N misses.
- R6: A reload value of 0 behaves as 1, so every miss raises the pulse, and address 0 still reads back 0.
- R7: A write to address 0 stores csr_wdata as the reload value and loads the counter with it on the next clock edge. A token strobe in the same cycle as that write has no effect.
- R8: irq_sticky sets on the same edge that irq_pulse rises, and it can be read as bit 0 of address 1.
- R9: A write to address 1 with bit 0 set clears irq_sticky. A write with bit 0 clear leaves it unchanged. An expiry in the same cycle as the clearing write keeps the flag set.
- R10: csr_rdata is registered: it shows the addressed register one cycle after csr_rd is high. Addresses 2 and 3 read as 0, and csr_rdata holds its value while csr_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W (2) | Register address: 0 reload, 1 status |
| csr_wdata | input | CNT_W (5) | Write data |
| csr_rdata | output | DATA_W (8) | Registered read data |
| tok_vld | input | 1 | One strobe per IN token |
| tok_match | input | 1 | Token targets the expected endpoint |
| irq_pulse | output | 1 | One-cycle mismatch interrupt |
| irq_sticky | output | 1 | Sticky interrupt flag (write-one-to-clear) |

## Verification
The counter cannot be read directly, so a wrong count shows up only in when irq_pulse fires. It appears at the earliest on the next expiry, which can be up to 31 misses after the fault. The worst case is a counter that fails to reload after a hit or after a register write. To bring such an error to the ports soon, the bench runs short and long reload values and places hits at different points in a run. It also compares the pulse, the sticky flag and the read data against a behavioural model on every cycle.

// File: rtl/emi_pkg.sv
package emi_pkg;
  localparam int unsigned REG_RELOAD = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned STS_IRQ_BIT = 0;
endpackage

// File: rtl/emi_csr.sv
module emi_csr #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned RST_CNT = 8,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              expire,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  reload_eff,
  output logic              sticky,
  output logic [DATA_W-1:0] rdata
);
  import emi_pkg::*;

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_CNT);

  logic [CNT_W-1:0] reload_q;
  logic             sel_reload;
  logic             sel_status;
  logic             clr_req;

  assign sel_reload = (addr == ADDR_W'(REG_RELOAD));
  assign sel_status = (addr == ADDR_W'(REG_STATUS));
  assign load       = wr && sel_reload;
  assign clr_req    = wr && sel_status && wdata[STS_IRQ_BIT];
  // a zero count behaves as one
  assign load_val   = (wdata == '0) ? ONE : wdata;
  assign reload_eff = (reload_q == '0) ? ONE : reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RST_VAL;
    end else if (load) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= 1'b0;
    end else if (expire) begin
      sticky <= 1'b1;
    end else if (clr_req) begin
      sticky <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (sel_reload) begin
        rdata <= DATA_W'(reload_q);
      end else if (sel_status) begin
        rdata <= DATA_W'(sticky);
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/emi_down_counter.sv
module emi_down_counter #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned RST_CNT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tok_vld,
  input  logic             tok_match,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_VAL = (RST_CNT == 0) ? ONE : CNT_W'(RST_CNT);

  logic miss;

  assign miss   = tok_vld && !tok_match && !load;
  assign expire = miss && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tok_vld) begin
      if (tok_match || expire) begin
        cnt_q <= reload_val;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/emi_irq_out.sv
module emi_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
    end else begin
      pulse <= expire;
    end
  end
endmodule

// File: rtl/emi_ctr.sv
module emi_ctr #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned RST_CNT = 8,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              tok_vld,
  input  logic              tok_match,
  output logic              irq_pulse,
  output logic              irq_sticky
);
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload_eff;
  logic             expire;
  logic [CNT_W-1:0] cnt_val;

  emi_csr #(
    .CNT_W(CNT_W), .RST_CNT(RST_CNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_csr (
    .clk(clk), .rst(rst), .wr(csr_wr), .rd(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .expire(expire), .load(load), .load_val(load_val),
    .reload_eff(reload_eff), .sticky(irq_sticky), .rdata(csr_rdata)
  );

  emi_down_counter #(
    .CNT_W(CNT_W), .RST_CNT(RST_CNT)
  ) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .reload_val(reload_eff), .tok_vld(tok_vld), .tok_match(tok_match),
    .expire(expire), .cnt_q(cnt_val)
  );

  emi_irq_out u_irq (
    .clk(clk), .rst(rst), .expire(expire), .pulse(irq_pulse)
  );
endmodule

// File: rtl/emi_ctr_chk.sv
module emi_ctr_chk #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_wr,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [CNT_W-1:0]  csr_wdata,
  input logic              tok_vld,
  input logic              tok_match,
  input logic              irq_pulse,
  input logic              irq_sticky,
  input logic [CNT_W-1:0]  cnt_val
);
  // R2
  pulse_needs_token_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tok_vld) |-> !irq_pulse);
  // R4
  match_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tok_vld && tok_match) |-> !irq_pulse);
  // R6
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_val != '0);
  // R7
  write_blocks_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $past(csr_wr && csr_addr == ADDR_W'(0)) |-> !irq_pulse);
  // R8
  sticky_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sticky) |-> irq_pulse);
  // R8
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_sticky);
  // R9
  sticky_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_sticky) |-> $past(csr_wr && csr_addr == ADDR_W'(1) && csr_wdata[0]));
endmodule

bind emi_ctr emi_ctr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .tok_vld(tok_vld), .tok_match(tok_match),
  .irq_pulse(irq_pulse), .irq_sticky(irq_sticky), .cnt_val(cnt_val)
);

// File: tb/emi_ctr_tb.sv
`timescale 1ns/1ps
module emi_ctr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csr_wr = 1'b0, csr_rd = 1'b0;
  logic [1:0] csr_addr = '0;
  logic [4:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       tok_vld = 1'b0, tok_match = 1'b0;
  logic       irq_pulse, irq_sticky;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  int m_reload = 8, m_cnt = 8, m_rdata = 0;
  bit m_pulse = 0, m_sticky = 0;

  always #2.5 clk = ~clk;

  emi_ctr u_dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .tok_vld(tok_vld), .tok_match(tok_match),
    .irq_pulse(irq_pulse), .irq_sticky(irq_sticky)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int eff;
    bit ex;
    cycles++;
    ex = 0;
    if (rst) begin
      m_reload = 8; m_cnt = 8; m_pulse = 0; m_sticky = 0; m_rdata = 0;
    end else begin
      eff = (m_reload == 0) ? 1 : m_reload;
      if (csr_rd) begin
        if (csr_addr == 0) m_rdata = m_reload;
        else if (csr_addr == 1) m_rdata = m_sticky;
        else m_rdata = 0;
      end
      if (csr_wr && csr_addr == 0) begin
        m_cnt = (csr_wdata == 0) ? 1 : csr_wdata;
      end else if (tok_vld) begin
        if (tok_match) m_cnt = eff;
        else if (m_cnt <= 1) begin ex = 1; m_cnt = eff; end
        else m_cnt--;
      end
      if (ex) m_sticky = 1;
      else if (csr_wr && csr_addr == 1 && csr_wdata[0]) m_sticky = 0;
      m_pulse = ex;
      if (csr_wr && csr_addr == 0) m_reload = csr_wdata;
    end
    #1;
    if (!done) begin
      check(cur_req, irq_pulse, m_pulse, "irq_pulse");
      check(cur_req, irq_sticky, m_sticky, "irq_sticky");
      check(cur_req, csr_rdata, m_rdata, "csr_rdata");
    end
  end

  task automatic cyc(bit wr, bit rd, int addr, int wd, bit tv, bit tm);
    @(negedge clk);
    csr_wr = wr; csr_rd = rd; csr_addr = 2'(addr); csr_wdata = 5'(wd);
    tok_vld = tv; tok_match = tm;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask
  task automatic miss(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0);
  endtask
  task automatic hit();
    cyc(0, 0, 0, 0, 1, 1);
  endtask
  task automatic wr_reg(int a, int d);
    cyc(1, 0, a, d, 0, 0);
  endtask
  task automatic rd_reg(int a);
    cyc(0, 1, a, 0, 0, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1"; rd_reg(0); idle(1);
    // R1 explicit reset read-back
    check("R1", csr_rdata, 8, "reset reload read");
    cur_req = "R2"; miss(7); idle(1); miss(1); idle(2);
    cur_req = "R8"; rd_reg(1); idle(1);
    check("R8", csr_rdata, 1, "sticky read");
    cur_req = "R9"; wr_reg(1, 0); idle(1); wr_reg(1, 1); idle(1);
    cur_req = "R3"; miss(3); idle(5); miss(5); idle(2);
    cur_req = "R4"; miss(5); hit(); miss(7); idle(2); miss(1); idle(1);
    cur_req = "R5"; miss(16); idle(2);
    cur_req = "R6"; wr_reg(0, 0); miss(3); rd_reg(0); idle(1);
    check("R6", csr_rdata, 0, "zero reload read");
    cur_req = "R7"; wr_reg(0, 3); miss(2); cyc(1, 0, 0, 3, 1, 0); miss(2); idle(1); miss(1); idle(1);
    wr_reg(0, 31); miss(30); idle(1); miss(1); idle(1);
    rd_reg(0); idle(1);
    check("R7", csr_rdata, 31, "reload read");
    cur_req = "R9"; wr_reg(0, 2); wr_reg(1, 1); miss(1);
    cyc(1, 0, 1, 1, 1, 0); idle(2);
    check("R9", irq_sticky, 1, "set beats clear");
    cur_req = "R10"; rd_reg(2); idle(1); rd_reg(3); idle(1); rd_reg(1); idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule